// File: doc/BRIEF.md
# Two-Wire Register-Space Slave with Supply-Fail Write Lockout

This block is a two-wire serial slave that gives a bus host byte access to a 64-location register space through one auto-incrementing pointer. The timekeeping registers sit at locations 0 to 7. Control is at 8 and the watchdog at 9. Alarm settings occupy 10 to 15, locations 16 to 18 are reserved, square-wave control is at 19, and general-purpose RAM fills 20 to 63. The storage itself lives outside the block. The block presents a location index, a one-cycle write strobe with its data byte, and takes back a read byte for the indexed location.

The raw SCL and SDA pins are oversampled on the system clock. The system clock must run at least eight times the SCL rate. The block pulls SDA low through an open-drain enable. In a write transfer, the byte after the device address loads the pointer and the bytes after it are stored. A read transfer begins at wherever the pointer currently stands.

A supply-fail input overrides the protocol engine. It cuts off any transfer in flight, releases SDA, and clears the pointer. While the flag is high the bus is ignored. After the flag drops, bus traffic is accepted again, but store strobes stay suppressed for a programmable number of clock cycles.

Top module: `twire_reg_slave`

## Requirements
- R1: Only the address byte D0h (7-bit address 68h with a 0 in bit 0 for write) or D1h (bit 0 set for read) following a start is acknowledged by driving SDA low during the ninth SCL pulse; any other address byte gets no acknowledge and the slave leaves SDA released.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 6 bits without producing a strobe; every later byte produces one `reg_wr_o` pulse with that byte at the current pointer, and each byte is acknowledged.
- R3: The pointer advances by one after every stored or transmitted data byte and wraps from 63 to 0.
- R4: A read transfer returns the byte at the current pointer, most significant bit first; it keeps sending successive locations while the host acknowledges, and after a host non-acknowledge SDA stays released until the next start.
- R5: Locations 16, 17 and 18 accept and acknowledge written bytes without a strobe, and read back as 00h.
- R6: A start seen in the middle of a transfer restarts address reception (repeated start) with the pointer kept, and a stop returns the slave to idle.
- R7: Within two clock cycles of the supply-fail flag rising, SDA is released and the pointer is 0, whatever transfer was in progress.
- R8: While the supply-fail flag is high, bus activity is ignored: no acknowledge is driven and no strobe is produced.
- R9: For `REC_CYC` clock cycles after the supply-fail flag falls, transfers are acknowledged but no strobe is produced; once that interval has passed, writes are stored again.
- R10: After reset, SDA is released, `reg_wr_o` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| pwr_fail_i | input | 1 | Supply-fail flag, active high |
| reg_addr_o | output | AW | Register location index (current pointer) |
| reg_wr_o | output | 1 | One-cycle store strobe |
| reg_wdata_o | output | 8 | Byte to store, valid with the strobe |
| reg_rdata_i | input | 8 | Byte held at `reg_addr_o` |

## Verification
The bench runs a burst that starts at location 62 and must land its third byte at location 0. A pointer that fails to wrap would spill into a nonexistent location 64 or corrupt location 63. Reserved locations are written with non-zero patterns and then read back. A slave that stored them would return the pattern instead of 00h, and one that refused them would fail to acknowledge. The supply flag is raised while the slave is driving a zero data bit. A design that only masked new inputs would keep SDA low and keep its pointer at 30. The bench then writes during the flag and also inside the recovery window, so a lockout that ended on the flag's falling edge would commit a byte the host believes was protected.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int N = STAGES + 1;

  logic [N-1:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[N-2:0], scl_i};
      sda_q <= {sda_q[N-2:0], sda_i};
    end
  end

  // stage N-2 is the synchronized level, stage N-1 the previous sample
  assign sda_lvl_o  = sda_q[N-2];
  assign scl_rise_o = scl_q[N-2] & ~scl_q[N-1];
  assign scl_fall_o = ~scl_q[N-2] & scl_q[N-1];
  assign start_o    = scl_q[N-2] & scl_q[N-1] & sda_q[N-1] & ~sda_q[N-2];
  assign stop_o     = scl_q[N-2] & scl_q[N-1] & ~sda_q[N-1] & sda_q[N-2];
endmodule

// File: rtl/tw_pwr_lock.sv
module tw_pwr_lock #(
  parameter int REC_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_fail_i,
  output logic wr_block_o
);
  localparam int CW = $clog2(REC_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pwr_fail_i)        cnt_d = CW'(REC_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wr_block_o = pwr_fail_i | (cnt_q != '0);
endmodule

// File: rtl/twire_reg_slave.sv
module twire_reg_slave
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         AW          = 6,
  parameter int         REC_CYC     = 1000,
  parameter int         RSV_LO      = 16,
  parameter int         RSV_HI      = 18,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          pwr_fail_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);
  localparam logic [AW-1:0] RSV_LO_A = AW'(RSV_LO);
  localparam logic [AW-1:0] RSV_HI_A = AW'(RSV_HI);

  // asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det, wr_block;

  tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  tw_pwr_lock #(.REC_CYC(REC_CYC)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pwr_fail_i(pwr_fail_i),
    .wr_block_o(wr_block)
  );

  tw_state_e     state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d, first_q, first_d, nack_q, nack_d;
  logic          oe_q, oe_d, wr_q, wr_d;
  logic          rsv_hit;
  logic [7:0]    rd_byte;

  assign rsv_hit = (ptr_q >= RSV_LO_A) && (ptr_q <= RSV_HI_A);
  assign rd_byte = rsv_hit ? 8'h00 : reg_rdata_i;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    first_d = first_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    wr_d    = 1'b0;
    if (pwr_fail_i) begin
      state_d = ST_IDLE;
      ptr_d   = '0;
      oe_d    = 1'b0;
      bit_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              rw_d    = sh_q[0];
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[7];
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              first_d = 1'b1;
              state_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            oe_d    = 1'b1;
            state_d = ST_WR_ACK;
            if (first_q) ptr_d = sh_q[AW-1:0];
            else         wr_d  = ~wr_block & ~rsv_hit;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bit_d   = '0;
            first_d = 1'b0;
            state_d = ST_WR;
            if (!first_q) ptr_d = ptr_q + AW'(1);
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + AW'(1);
              state_d = ST_RD_ACK;
            end else if (bit_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_lvl;
          end else if (scl_fall) begin
            if (nack_q) begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end else begin
              sh_d    = rd_byte;
              oe_d    = ~rd_byte[7];
              bit_d   = '0;
              state_d = ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = sh_q;
endmodule

// File: rtl/twire_reg_slave_chk.sv
module twire_reg_slave_chk #(
  parameter int AW      = 6,
  parameter int REC_CYC = 1000,
  parameter int RSV_LO  = 16,
  parameter int RSV_HI  = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_fail_i,
  input logic          sda_oe_o,
  input logic          reg_wr_o,
  input logic [AW-1:0] reg_addr_o
);
  localparam int QW = $clog2(REC_CYC + 2) + 1;

  // cycles since the supply flag was last high, saturating above REC_CYC
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         quiet_q <= QW'(REC_CYC + 1);
    else if (pwr_fail_i)                 quiet_q <= '0;
    else if (quiet_q <= QW'(REC_CYC))    quiet_q <= quiet_q + QW'(1);
  end

  // R7
  pf_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> (!sda_oe_o && reg_addr_o == '0));

  // R8
  pf_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !reg_wr_o);

  // R9
  rec_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (quiet_q > QW'(REC_CYC)));

  // R5
  rsv_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (int'(reg_addr_o) < RSV_LO || int'(reg_addr_o) > RSV_HI));

  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
endmodule

bind twire_reg_slave twire_reg_slave_chk #(
  .AW(AW), .REC_CYC(REC_CYC), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_fail_i(pwr_fail_i),
  .sda_oe_o  (sda_oe_o),
  .reg_wr_o  (reg_wr_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/twire_reg_slave_tb_top.sv
`timescale 1ns/1ps
module twire_reg_slave_tb_top;
  localparam int AW  = 6;
  localparam int REC = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, pf = 1'b0;
  logic sda_oe, reg_wr, sda_line;
  logic [AW-1:0] reg_addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [64];
  int checks = 0, fails = 0, wr_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rdata    = mem[reg_addr];

  twire_reg_slave #(.AW(AW), .REC_CYC(REC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pwr_fail_i(pf), .reg_addr_o(reg_addr),
    .reg_wr_o(reg_wr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  always @(posedge clk) if (reg_wr) begin
    mem[reg_addr] <= wdata;
    wr_cnt <= wr_cnt + 1;
  end

  // {location, byte written, byte expected on read-back}
  localparam logic [23:0] VEC [0:7] = '{
    24'h00_59_59, 24'h07_24_24, 24'h10_AA_00, 24'h12_55_00,
    24'h13_3C_3C, 24'h14_FF_FF, 24'h3F_81_81, 24'h09_00_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(); repeat (5) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1; hold(); m_scl = 1; hold(); m_sda = 0; hold(); m_scl = 0; hold(); endtask
  task automatic bus_stop();  m_sda = 0; hold(); m_scl = 1; hold(); m_sda = 1; hold(); endtask
  task automatic send_bit(input logic v); m_sda = v; hold(); m_scl = 1; hold(); hold(); m_scl = 0; hold(); endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; hold(); m_scl = 1; hold(); acked = ~sda_line; hold(); m_scl = 0; hold();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(); m_scl = 1; hold(); b[i] = sda_line; hold(); m_scl = 0;
    end
    m_sda = ~ack; hold(); m_scl = 1; hold(); hold(); m_scl = 0; hold(); m_sda = 1;
  endtask

  // write: address D0h, pointer byte, then data; returns AND of all acks
  task automatic wr_xfer(input logic [7:0] p, input logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    bus_start(); send_byte(8'hD0, a0); send_byte(p, a1); send_byte(d, a2); bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic rd_one(output logic [7:0] b);
    logic a;
    bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, b); bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak, ak2;
    logic [7:0] b, b1, b2;
    int wc;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    // R10 reset state
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 reg_wr", reg_wr, 0);
    chk("R10 pointer", reg_addr, 0);

    // R1 foreign address is not acknowledged
    bus_start(); send_byte(8'hA0, ak); bus_stop();
    chk("R1 foreign address ack", ak, 0);

    // R1 R2 R4 R5 vector table: write then read back
    for (int v = 0; v < 8; v++) begin
      wr_xfer(VEC[v][23:16], VEC[v][15:8], ak);
      chk("R1 R2 R5 write acks", ak, 1);
      bus_start(); send_byte(8'hD0, ak); send_byte(VEC[v][23:16], ak2); bus_stop();
      rd_one(b);
      chk("R2 R4 R5 read-back", b, VEC[v][7:0]);
    end

    // R3 burst across the top of the space
    bus_start(); send_byte(8'hD0, ak); send_byte(8'd62, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak2); bus_stop();
    chk("R3 burst wrap store 62", mem[62], 8'h11);
    chk("R3 burst wrap store 63", mem[63], 8'h22);
    chk("R3 burst wrap store 0", mem[0], 8'h33);
    bus_start(); send_byte(8'hD0, ak); send_byte(8'd62, ak); bus_stop();
    bus_start(); send_byte(8'hD1, ak);
    recv_byte(1'b1, b); recv_byte(1'b1, b1); recv_byte(1'b0, b2);
    repeat (3) @(negedge clk);
    chk("R4 sda released after nack", sda_oe, 0);
    bus_stop();
    chk("R3 R4 sequential read 62", b, 8'h11);
    chk("R3 R4 sequential read 63", b1, 8'h22);
    chk("R3 R4 sequential read wrap", b2, 8'h33);

    // R6 repeated start keeps the pointer
    wr_xfer(8'h05, 8'hC3, ak);
    bus_start(); send_byte(8'hD0, ak); send_byte(8'h05, ak);
    bus_start(); send_byte(8'hD1, ak); recv_byte(1'b0, b); bus_stop();
    chk("R6 repeated-start read", b, 8'hC3);
    chk("R6 repeated-start address ack", ak, 1);

    // R7 supply fail while the slave drives a zero bit
    bus_start(); send_byte(8'hD0, ak); send_byte(8'd30, ak);
    bus_start(); send_byte(8'hD1, ak);
    hold();
    chk("R7 slave driving before fail", sda_oe, 1);
    @(negedge clk); pf = 1;
    repeat (2) @(negedge clk);
    chk("R7 sda released on fail", sda_oe, 0);
    chk("R7 pointer cleared on fail", reg_addr, 0);
    bus_stop();

    // R8 bus ignored while the flag is high
    wc = wr_cnt;
    wr_xfer(8'd40, 8'h5A, ak);
    chk("R8 no ack during fail", ak, 0);
    chk("R8 no store during fail", wr_cnt, wc);

    // R7 read after release starts at location 0; R9 recovery window
    @(negedge clk); pf = 0;
    rd_one(b);
    chk("R7 read from cleared pointer", b, 8'h33);
    wr_xfer(8'd41, 8'h77, ak);
    chk("R9 acks during recovery", ak, 1);
    chk("R9 no store during recovery", wr_cnt, wc);
    chk("R9 location untouched", mem[41], 8'h00);
    repeat (REC + 100) @(negedge clk);
    wr_xfer(8'd41, 8'h77, ak);
    chk("R9 store after recovery", mem[41], 8'h77);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule